// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block is the data-hazard controller of a five-stage in-order integer pipeline. While a consumer instruction sits in decode, it compares that instruction's two source register numbers against the destination registers of the two older instructions now in execute and memory. From that comparison it chooses, one cycle ahead, which bypass feeds each ALU operand once the consumer reaches execute. The result is either the register file, the older instruction's result that will be in the EX/MEM register, or the oldest in-flight result that will be in the MEM/WB register.

A load in execute whose destination is a source of the decoding instruction cannot be bypassed in time. For this case the block raises a stall, which freezes the PC and the IF/ID register, and a bubble, which zeroes the control write enables of the ID/EX register. One cycle later the load has moved to memory, and the held consumer picks up its data through the MEM/WB bypass. A producer three slots ahead needs no action, because the register file writes in the first half of a cycle and reads in the second half. Register 0 and producers that do not write a register never match.

Top module: `fwd_hazard_unit`

## Requirements
- R1: During and after reset, both operand selects are 2'b00. The select encoding is 2'b00 register file, 2'b01 EX/MEM bypass, 2'b10 MEM/WB bypass. The value 2'b11 never appears.
- R2: A decode source equal to the execute-stage destination sets that operand's select to 2'b01 on the next cycle. This holds when the source is non-zero, the producer writes, and there is no stall.
- R3: A decode source equal to the memory-stage destination sets that select to 2'b10 on the next cycle. This holds when the source is non-zero, the producer writes, and there is no execute-stage match. It applies when that producer is a load.
- R4: Stall and bubble are high in the same cycle whenever three conditions hold: the execute stage holds a load, that load writes a non-zero destination, and the destination equals either decode source.
- R5: When the execute and memory stages both match the same source, the execute-stage producer wins, giving select 2'b01.
- R6: In the cycle after a stall, both selects are 2'b00, since the bubble entering execute has no sources.
- R7: A source of 0, or a producer whose write enable is low, causes no forwarding and no stall.
- R8: A source with no match in execute or memory selects 2'b00 on the next cycle. This covers a producer three slots ahead that has already left memory.
- R9: A match against a non-load producer in execute causes no stall or bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_a | input | REG_W | First source register of the instruction in decode |
| id_src_b | input | REG_W | Second source register of the instruction in decode |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| mem_dst | input | REG_W | Destination register of the instruction in memory |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| stall | output | 1 | Hold PC and IF/ID this cycle |
| bubble | output | 1 | Clear control enables written into ID/EX this cycle |
| fwd_a | output | 2 | Operand A source select for the instruction in execute |
| fwd_b | output | 2 | Operand B source select for the instruction in execute |

## Verification
Stall and bubble are combinational, so they are due in the same cycle as the decode and execute inputs. The bench samples them a short delay after driving those inputs on the falling edge. The operand selects are registered, so they are due one rising edge after the inputs they depend on. The bench keeps the expected selects computed from the previous cycle's drive and compares them on the next falling edge, before it drives anything new. Directed sequences cover priority, register 0, write-enable gating, a load two slots ahead and the cycle after a stall. Seeded random traffic over a four-register space produces frequent collisions.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  output logic             stall,
  output logic             bubble,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);

  localparam logic [1:0] SEL_RF    = 2'b00;
  localparam logic [1:0] SEL_EXMEM = 2'b01;
  localparam logic [1:0] SEL_MEMWB = 2'b10;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_live, mem_live;
  logic a_hit_ex, b_hit_ex, a_hit_mem, b_hit_mem;
  logic load_use;
  logic [1:0] nxt_a, nxt_b;

  assign ex_live  = ex_wen  && (ex_dst  != ZERO_REG);
  assign mem_live = mem_wen && (mem_dst != ZERO_REG);

  assign a_hit_ex  = ex_live  && (ex_dst  == id_src_a);
  assign b_hit_ex  = ex_live  && (ex_dst  == id_src_b);
  assign a_hit_mem = mem_live && (mem_dst == id_src_a);
  assign b_hit_mem = mem_live && (mem_dst == id_src_b);

  assign load_use = ex_is_load && (a_hit_ex || b_hit_ex);
  assign stall    = load_use;
  assign bubble   = load_use;

  always_comb begin
    nxt_a = SEL_RF;
    if (!load_use) begin
      if (a_hit_ex)       nxt_a = SEL_EXMEM;
      else if (a_hit_mem) nxt_a = SEL_MEMWB;
    end
  end

  always_comb begin
    nxt_b = SEL_RF;
    if (!load_use) begin
      if (b_hit_ex)       nxt_b = SEL_EXMEM;
      else if (b_hit_mem) nxt_b = SEL_MEMWB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_a <= SEL_RF;
      fwd_b <= SEL_RF;
    end else begin
      fwd_a <= nxt_a;
      fwd_b <= nxt_b;
    end
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R1

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_is_load && ex_wen && ex_dst != ZERO_REG)); // R4

  AST_BUBBLE_EMPTY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (fwd_a == SEL_RF && fwd_b == SEL_RF)); // R6

  AST_ZERO_SRC_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == ZERO_REG) |=> (fwd_a == SEL_RF)); // R7

  AST_EX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_is_load && ex_wen && ex_dst != ZERO_REG && ex_dst == id_src_b) |=> (fwd_b == SEL_EXMEM)); // R5

  AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen || !ex_is_load) |-> !stall); // R9

endmodule

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0;
  logic stall, bubble;
  logic [1:0] fwd_a, fwd_b;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_a = 2'b00, exp_b = 2'b00;
  logic armed = 1'b0;
  string last_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_hazard_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .stall(stall), .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  function automatic logic want_stall(logic [RW-1:0] a, logic [RW-1:0] b,
                                      logic [RW-1:0] ed, logic ew, logic el);
    return el && ew && (ed != 0) && (ed == a || ed == b);
  endfunction

  function automatic logic [1:0] want_sel(logic [RW-1:0] s, logic [RW-1:0] ed, logic ew,
                                          logic [RW-1:0] md, logic mw, logic stl);
    if (stl) return 2'b00;
    if (s != 0 && ew && ed == s) return 2'b01;
    if (s != 0 && mw && md == s) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one cycle: verify registered selects due from previous drive, drive new inputs, verify stall
  task automatic step(logic [RW-1:0] a, logic [RW-1:0] b, logic [RW-1:0] ed, logic ew,
                      logic el, logic [RW-1:0] md, logic mw, string tag);
    logic st;
    @(negedge clk);
    if (armed) begin
      check(last_tag, "fwd_a", fwd_a, exp_a);
      check(last_tag, "fwd_b", fwd_b, exp_b);
    end
    id_src_a = a; id_src_b = b; ex_dst = ed; ex_wen = ew; ex_is_load = el;
    mem_dst = md; mem_wen = mw;
    #1;
    st = want_stall(a, b, ed, ew, el);
    check(tag, "stall", {1'b0, stall}, {1'b0, st});
    check(tag, "bubble", {1'b0, bubble}, {1'b0, st});
    exp_a = want_sel(a, ed, ew, md, mw, st);
    exp_b = want_sel(b, ed, ew, md, mw, st);
    armed = 1'b1;
    last_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", "fwd_a reset", fwd_a, 2'b00);
    check("R1", "fwd_b reset", fwd_b, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: ALU producer one ahead
    step(5'd3, 5'd4, 5'd3, 1'b1, 1'b0, 5'd9, 1'b1, "R2");
    // R3: producer two ahead, operand b
    step(5'd6, 5'd7, 5'd1, 1'b1, 1'b0, 5'd7, 1'b1, "R3");
    // R5: both stages hold same dest
    step(5'd8, 5'd8, 5'd8, 1'b1, 1'b0, 5'd8, 1'b1, "R5");
    // R7: register 0 never forwards or stalls
    step(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, "R7");
    // R7: write enables low
    step(5'd2, 5'd2, 5'd2, 1'b0, 1'b1, 5'd2, 1'b0, "R7");
    // R8: no match (producer already retired)
    step(5'd10, 5'd11, 5'd12, 1'b1, 1'b0, 5'd13, 1'b1, "R8");
    // R4 then R6, then load moved to memory -> R3 via MEM/WB
    step(5'd5, 5'd1, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, "R4");
    step(5'd5, 5'd1, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, "R6");
    step(5'd5, 5'd1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, "R3");
    // R4 on operand b, R9 non-load match
    step(5'd1, 5'd6, 5'd6, 1'b1, 1'b1, 5'd1, 1'b1, "R4");
    step(5'd6, 5'd2, 5'd6, 1'b1, 1'b0, 5'd2, 1'b1, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [RW-1:0] ra, rb, re, rm;
      logic we_e, ld, we_m;
      string tag;
      ra = RW'($urandom_range(0, 3));
      rb = RW'($urandom_range(0, 3));
      re = RW'($urandom_range(0, 3));
      rm = RW'($urandom_range(0, 3));
      we_e = 1'($urandom_range(0, 1));
      ld = 1'($urandom_range(0, 1));
      we_m = 1'($urandom_range(0, 1));
      if (want_stall(ra, rb, re, we_e, ld)) tag = "R4";
      else if (we_e && re != 0 && (re == ra || re == rb)) tag = (we_m && rm == re) ? "R5" : "R2";
      else if (we_m && rm != 0 && (rm == ra || rm == rb)) tag = "R3";
      else if (ra == 0 || rb == 0) tag = "R7";
      else tag = "R8";
      step(ra, rb, re, we_e, ld, rm, we_m, tag);
    end
    @(negedge clk);
    check(last_tag, "fwd_a", fwd_a, exp_a);
    check(last_tag, "fwd_b", fwd_b, exp_b);
    summary();
    $finish;
  end
endmodule